// File: doc/BRIEF.md
# Jump and Call-Return Redirect Unit

This decode-stage unit looks at the instruction word and decides whether it redirects the fetch stream without a condition. There are four kinds of redirect: a plain jump, a jump that also writes a link register, a jump through a register value, and a call and return pair. The call and return pair uses a small hardware stack of return addresses that lives inside the unit. For the immediate forms, the target is the 26-bit instruction field minus one. Fetch increments its counter after a redirect, so the first instruction fetched after a redirect is the field value itself.

Each redirect raises both a redirect strobe and a flush of the younger fetched instruction. The unit works out the target combinationally from the instruction that is present in the current cycle. A call pushes PC+1 on the clock edge, and a return pops the entry it used on the clock edge. Both actions happen only while the input that marks the instruction as valid is high. The surrounding pipeline supplies PC+1 and the value already read for the rs register. The unit returns the redirect, the flush and a link write request.

Top module: `jump_redirect_unit`

## Requirements
- R1: Opcode 2 (instr[31:26]) redirects to the zero-extended instr[25:0] minus one and asserts flush.
- R2: Opcode 3 redirects to instr[25:0] minus one, asserts flush and requests a link write of pc_plus1 to register 31.
- R3: Opcode 0 with function code 8 (instr[5:0]) redirects to rs_value and asserts flush.
- R4: Opcode 14 redirects to instr[25:0] minus one, asserts flush and pushes pc_plus1 onto the return stack at the clock edge.
- R5: Opcode 15 with a non-empty stack redirects to the most recently pushed entry, asserts flush and removes that entry at the clock edge.
- R6: Opcode 15 with an empty stack gives no redirect, no flush and no stack change.
- R7: A push onto a full stack discards the oldest entry. The following DEPTH returns then yield the last DEPTH pushed addresses, newest first.
- R8: Every other opcode, and opcode 0 with any function other than 8, gives no redirect, no flush and no link write, and leaves the stack unchanged.
- R9: While instr_valid is low, no redirect, flush or link write is raised and the stack does not change.
- R10: Synchronous active-high reset empties the return stack.
- R11: Target arithmetic wraps modulo 2^AW, so a zero field gives an all-ones target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction in decode is valid |
| instr | input | 32 | Instruction word |
| pc_plus1 | input | AW | Address of the next sequential instruction |
| rs_value | input | AW | Value of the rs source register |
| redir_valid | output | 1 | Redirect fetch to redir_addr |
| redir_addr | output | AW | Redirect target |
| flush | output | 1 | Squash the younger fetched instruction |
| link_we | output | 1 | Link register write request |
| link_addr | output | 5 | Link register index (31) |
| link_data | output | AW | Link value (pc_plus1) |

## Verification
The bench builds the unit with AW=32 and DEPTH=4. The shallow stack lets a short run of calls reach the full condition, and random call and return mixes hit overflow and underflow many times. A 32-bit width lets random rs values and PC values cover the full address range, including the wrap of a zero target field to all ones.

// File: rtl/jru_pkg.sv
package jru_pkg;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_JUMP    = 6'd2;
    localparam logic [5:0] OPC_LINK    = 6'd3;
    localparam logic [5:0] OPC_CALL    = 6'd14;
    localparam logic [5:0] OPC_RET     = 6'd15;
    localparam logic [5:0] FN_JREG     = 6'd8;
    localparam logic [4:0] LINK_REG    = 5'd31;

    typedef enum logic [2:0] {
        K_NONE,
        K_JUMP,
        K_LINK,
        K_REG,
        K_CALL,
        K_RET
    } kind_e;

    typedef struct packed {
        logic push;
        logic pop;
    } stk_op_t;

    function automatic kind_e classify(input logic [5:0] opc, input logic [5:0] fn);
        kind_e k;
        case (opc)
            OPC_JUMP:    k = K_JUMP;
            OPC_LINK:    k = K_LINK;
            OPC_CALL:    k = K_CALL;
            OPC_RET:     k = K_RET;
            OPC_SPECIAL: k = (fn == FN_JREG) ? K_REG : K_NONE;
            default:     k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/jru_decode.sv
module jru_decode
    import jru_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          valid,
    input  logic [31:0]   instr,
    output kind_e         kind,
    output logic [AW-1:0] imm_target
);
    always_comb begin
        kind       = valid ? classify(instr[31:26], instr[5:0]) : K_NONE;
        imm_target = AW'(instr[25:0]) - AW'(1);
    end
endmodule

// File: rtl/jru_ret_stack.sv
module jru_ret_stack
    import jru_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_t       op,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;
    logic [PW-1:0] top_ptr;
    logic [PW-1:0] nxt_ptr;

    always_comb begin
        top_ptr  = (wr_ptr == '0) ? LAST : wr_ptr - PW'(1);
        nxt_ptr  = (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
        empty    = (count == '0);
        top_data = mem[top_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (op.push) begin
            wr_ptr <= nxt_ptr;
            if (count != FULL) count <= count + CW'(1);
        end else if (op.pop && !empty) begin
            wr_ptr <= top_ptr;
            count  <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (op.push) mem[wr_ptr] <= push_data;
    end

    a_r7_full_saturates: assert property (@(posedge clk) disable iff (rst)
        (op.push && count == FULL) |=> (count == FULL));
    a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (op.pop && !op.push && count != '0) |=> (count == $past(count) - CW'(1)));
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);
endmodule

// File: rtl/jump_redirect_unit.sv
module jump_redirect_unit
    import jru_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    input  logic [31:0]   instr,
    input  logic [AW-1:0] pc_plus1,
    input  logic [AW-1:0] rs_value,
    output logic          redir_valid,
    output logic [AW-1:0] redir_addr,
    output logic          flush,
    output logic          link_we,
    output logic [4:0]    link_addr,
    output logic [AW-1:0] link_data
);
    kind_e         kind;
    logic [AW-1:0] imm_target;
    logic [AW-1:0] stk_top;
    logic          stk_empty;
    stk_op_t       stk_op;

    jru_decode #(.AW(AW)) i_decode (
        .valid      (instr_valid),
        .instr      (instr),
        .kind       (kind),
        .imm_target (imm_target)
    );

    jru_ret_stack #(.AW(AW), .DEPTH(DEPTH)) i_stack (
        .clk       (clk),
        .rst       (rst),
        .op        (stk_op),
        .push_data (pc_plus1),
        .top_data  (stk_top),
        .empty     (stk_empty)
    );

    always_comb begin
        redir_valid = 1'b0;
        redir_addr  = imm_target;
        link_we     = 1'b0;
        stk_op      = '0;
        case (kind)
            K_JUMP: redir_valid = 1'b1;
            K_LINK: begin
                redir_valid = 1'b1;
                link_we     = 1'b1;
            end
            K_REG: begin
                redir_valid = 1'b1;
                redir_addr  = rs_value;
            end
            K_CALL: begin
                redir_valid = 1'b1;
                stk_op.push = 1'b1;
            end
            K_RET: begin
                redir_valid = !stk_empty;
                redir_addr  = stk_top;
                stk_op.pop  = !stk_empty;
            end
            default: ;
        endcase
        flush     = redir_valid;
        link_addr = LINK_REG;
        link_data = pc_plus1;
    end

    a_r9_idle_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!redir_valid && !link_we && !flush));
    a_r6_empty_return_quiet: assert property (@(posedge clk) disable iff (rst)
        (kind == K_RET && stk_empty) |-> !redir_valid);
    a_r2_link_with_redirect: assert property (@(posedge clk) disable iff (rst)
        link_we |-> redir_valid);
    a_r4_call_fills_stack: assert property (@(posedge clk) disable iff (rst)
        (kind == K_CALL) |=> !stk_empty);
    a_r10_empty_after_reset: assert property (@(posedge clk)
        $past(rst) |-> stk_empty);
endmodule

// File: tb/test_jump_redirect_unit.sv
module test_jump_redirect_unit;
    localparam int AW     = 32;
    localparam int DEPTH  = 4;
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [AW-1:0] pc_plus1 = '0;
    logic [AW-1:0] rs_value = '0;
    logic          redir_valid, flush, link_we;
    logic [AW-1:0] redir_addr, link_data;
    logic [4:0]    link_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [AW-1:0] mstk [DEPTH];
    int            mcnt = 0;

    jump_redirect_unit #(.AW(AW), .DEPTH(DEPTH)) i_jump_redirect_unit (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .pc_plus1(pc_plus1), .rs_value(rs_value), .redir_valid(redir_valid),
        .redir_addr(redir_addr), .flush(flush), .link_we(link_we),
        .link_addr(link_addr), .link_data(link_data)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input int opc, input logic [25:0] fld);
        return {opc[5:0], fld};
    endfunction

    function automatic string tag_of(input logic v, input logic [31:0] w);
        if (!v) return "R9";
        case (w[31:26])
            6'd2:  return "R1";
            6'd3:  return "R2";
            6'd14: return "R4";
            6'd15: return "R5/R6";
            6'd0:  return (w[5:0] == 6'd8) ? "R3" : "R8";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive one instruction, check outputs mid-cycle, advance model at the edge
    task automatic step(input logic v, input logic [31:0] w, input logic [AW-1:0] pc,
                        input logic [AW-1:0] rs, input string tagx);
        logic          ev, el;
        logic [AW-1:0] ea;
        logic [AW-1:0] imm;
        string         tg;
        int            op;
        @(negedge clk);
        instr_valid = v; instr = w; pc_plus1 = pc; rs_value = rs;
        imm = AW'(w[25:0]) - AW'(1);
        op  = int'(w[31:26]);
        ev = 1'b0; el = 1'b0; ea = '0;
        if (v) begin
            if (op == 2 || op == 14) begin ev = 1'b1; ea = imm; end
            else if (op == 3) begin ev = 1'b1; el = 1'b1; ea = imm; end
            else if (op == 0 && w[5:0] == 6'd8) begin ev = 1'b1; ea = rs; end
            else if (op == 15 && mcnt > 0) begin ev = 1'b1; ea = mstk[mcnt-1]; end
        end
        tg = (tagx != "") ? tagx : tag_of(v, w);
        #1;
        check(tg, "redir_valid", AW'(redir_valid), AW'(ev));
        check(tg, "flush", AW'(flush), AW'(ev));
        check(tg, "link_we", AW'(link_we), AW'(el));
        if (ev) check(tg, "redir_addr", redir_addr, ea);
        if (el) begin
            check(tg, "link_addr", AW'(link_addr), AW'(31));
            check(tg, "link_data", link_data, pc);
        end
        if (v && op == 14) begin
            if (mcnt == DEPTH) begin
                for (int i = 0; i < DEPTH - 1; i++) mstk[i] = mstk[i+1];
                mstk[DEPTH-1] = pc;
            end else begin
                mstk[mcnt] = pc;
                mcnt++;
            end
        end else if (v && op == 15 && mcnt > 0) begin
            mcnt--;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: stack empty after reset, so a return does nothing
        step(1'b1, mk(15, 26'h0), 32'h100, 32'h0, "R10");
        step(1'b0, mk(2, 26'h55), 32'h101, 32'h0, "R9");
        step(1'b1, mk(2, 26'h1234), 32'h10, 32'h0, "R1");
        step(1'b1, mk(2, 26'h0), 32'h11, 32'h0, "R11");
        step(1'b1, mk(3, 26'h3ffffff), 32'h12, 32'h0, "R2");
        step(1'b1, {6'd0, 20'h0, 6'd8}, 32'h13, 32'hdeadbeef, "R3");
        step(1'b1, {6'd0, 20'h0, 6'd9}, 32'h14, 32'hdeadbeef, "R8");
        step(1'b1, mk(35, 26'h77), 32'h15, 32'h0, "R8");
        // invalid call must not push: return right after stays quiet
        step(1'b0, mk(14, 26'h40), 32'h16, 32'h0, "R9");
        step(1'b1, mk(15, 26'h0), 32'h17, 32'h0, "R9");
        step(1'b1, mk(14, 26'h200), 32'h20, 32'h0, "R4");
        step(1'b1, mk(15, 26'h0), 32'h21, 32'h0, "R5");
        step(1'b1, mk(15, 26'h0), 32'h22, 32'h0, "R6");
        // R7: overflow then drain
        for (int i = 0; i < DEPTH + 2; i++)
            step(1'b1, mk(14, 26'(i + 1)), AW'(32'h1000 + i), 32'h0, "R7");
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, mk(15, 26'h0), 32'h2000, 32'h0, "R7");
        step(1'b1, mk(15, 26'h0), 32'h2001, 32'h0, "R6");
        // random mix
        for (int n = 0; n < 600; n++) begin
            int            pick;
            int            ops [7];
            logic [31:0]   w;
            ops = '{0, 2, 3, 14, 15, 15, 41};
            pick = int'($urandom_range(0, 6));
            w = {ops[pick][5:0], 26'($urandom)};
            if (ops[pick] == 0 && $urandom_range(0, 2) != 0) w[5:0] = 6'd8;
            step($urandom_range(0, 7) != 0, w, AW'($urandom), AW'($urandom), "");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule